// File: doc/BRIEF.md
# Overload Hiccup Restart Timer

This block is the digital model of the overload integrator and the restart sequencer of a switching-converter controller. A strobe marks each switching-cycle boundary, and a flag reports whether cycle-by-cycle current limiting acted in the cycle that just ended. An up/down overload level integrates these reports. It rises by a large step on a limited cycle and falls by a smaller step on a clean one. When it reaches a programmable trip level, the block starts a hiccup restart. The restart clears the overload level and the soft-start level. It then lets soft start climb at 1/110 of its normal rate until the pulse-width modulator reports its first output pulse, after which the normal rate returns.

A two-bit mode input picks one of four protection styles. The styles are limit-only, immediate, delayed and externally triggered, and an external trigger forces a restart at once. The step sizes, trip level, soft-start step, soft-start ceiling and first-pulse level are all inputs, so that a register file outside the block can program them. Typical step values keep a 22:12 ratio between rise and fall. The clear outputs drive the discharge switches of the analogue side.

Top module: `hiccup_restart_timer`

## Requirements
- R1: With prot_mode = 2 (delayed), ovl_level rises by up_step, saturating at all ones, on a clock where cyc_strobe and ilim_evt are both high. It falls by down_step, floored at zero, on a clock where cyc_strobe is high and ilim_evt is low. It holds on every clock without cyc_strobe.
- R2: With prot_mode = 2, when a limited strobe brings the rise result to trip_level or above, the next clock shows hiccup_active = 1, ovl_level = 0 and ss_level = 0. ovl_clr and ss_clr are high for exactly that one clock.
- R3: While hiccup_active is high, ss_level advances by ss_step once every 110 clocks. The first advance comes 110 clocks after the clearing edge.
- R4: hiccup_active falls on the clock after first_pulse is seen with ss_level at or above pulse_level. A first_pulse seen below that level leaves hiccup_active high.
- R5: While hiccup_active is low, ss_level advances by ss_step on every clock and saturates at ss_full.
- R6: prot_mode = 0 (limit only): neither limited strobes nor ext_trig start a restart, and ovl_level is held at zero.
- R7: prot_mode = 1 (immediate): the first strobe with ilim_evt high starts a restart. ilim_evt without a strobe does not, and ovl_level is held at zero.
- R8: prot_mode = 3 (external only): limited strobes do not start a restart and ovl_level is held at zero, while ext_trig does start one.
- R9: In modes 1, 2 and 3, ext_trig starts a restart on the next clock with or without a strobe. This also applies during a restart already in progress.
- R10: When a restart request and a qualifying first_pulse fall on the same clock, the restart wins: hiccup_active stays high and ss_level is cleared.
- R11: While rst_n is low, hiccup_active, ss_level, ovl_level, ovl_clr and ss_clr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_strobe | input | 1 | One-clock marker at each switching-cycle boundary |
| ilim_evt | input | 1 | Current limit acted in the cycle now ending |
| first_pulse | input | 1 | Modulator produced an output pulse |
| ext_trig | input | 1 | External restart request |
| prot_mode | input | 2 | 0 limit only, 1 immediate, 2 delayed, 3 external only |
| trip_level | input | ACC_W | Overload level that starts a restart |
| up_step | input | ACC_W | Rise per limited cycle |
| down_step | input | ACC_W | Fall per clean cycle |
| ss_step | input | SS_W | Soft-start increment |
| ss_full | input | SS_W | Soft-start ceiling |
| pulse_level | input | SS_W | Soft-start level at which the first pulse may appear |
| hiccup_active | output | 1 | Restart in progress, from trigger until first pulse |
| ss_level | output | SS_W | Soft-start level |
| ovl_level | output | ACC_W | Overload integrator level |
| ovl_clr | output | 1 | One-clock discharge command for the overload integrator |
| ss_clr | output | 1 | One-clock discharge command for soft start |

## Verification
The restart request and the first-pulse release are the two functions that can land on the same clock. The bench lets a restart run for 110 clocks so that ss_level reaches pulse_level. It then raises first_pulse and ext_trig together for one clock. After that edge, hiccup_active must still be high, ss_level must be back at zero and ss_clr must pulse. A second slow climb must then be followed by a clean release.

// File: rtl/hiccup_restart_timer.sv
module hiccup_restart_timer #(
  parameter int ACC_W    = 16,
  parameter int SS_W     = 16,
  parameter int SLOW_DIV = 110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_strobe,
  input  logic             ilim_evt,
  input  logic             first_pulse,
  input  logic             ext_trig,
  input  logic [1:0]       prot_mode,
  input  logic [ACC_W-1:0] trip_level,
  input  logic [ACC_W-1:0] up_step,
  input  logic [ACC_W-1:0] down_step,
  input  logic [SS_W-1:0]  ss_step,
  input  logic [SS_W-1:0]  ss_full,
  input  logic [SS_W-1:0]  pulse_level,
  output logic             hiccup_active,
  output logic [SS_W-1:0]  ss_level,
  output logic [ACC_W-1:0] ovl_level,
  output logic             ovl_clr,
  output logic             ss_clr
);

  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);
  localparam logic [1:0] MODE_LIMIT = 2'd0;
  localparam logic [1:0] MODE_IMMED = 2'd1;
  localparam logic [1:0] MODE_DELAY = 2'd2;

  logic [DIV_W-1:0] div_cnt;

  logic [ACC_W:0]   up_sum;
  logic [ACC_W-1:0] up_sat, down_val;
  logic [SS_W:0]    ss_sum;
  logic [SS_W-1:0]  ss_next;
  logic integ_on, trip, release_now, slow_tick, ss_adv;

  assign up_sum   = {1'b0, ovl_level} + {1'b0, up_step};
  assign up_sat   = up_sum[ACC_W] ? '1 : up_sum[ACC_W-1:0];
  assign down_val = (ovl_level > down_step) ? ovl_level - down_step : '0;
  assign integ_on = (prot_mode == MODE_DELAY);

  assign trip = (ext_trig && prot_mode != MODE_LIMIT)
             || (prot_mode == MODE_IMMED && cyc_strobe && ilim_evt)
             || (integ_on && cyc_strobe && ilim_evt && up_sat >= trip_level);

  assign release_now = hiccup_active && first_pulse && (ss_level >= pulse_level);

  assign slow_tick = (div_cnt == DIV_LAST);
  assign ss_adv    = hiccup_active ? slow_tick : 1'b1;
  assign ss_sum    = {1'b0, ss_level} + {1'b0, ss_step};
  assign ss_next   = (ss_sum >= {1'b0, ss_full}) ? ss_full : ss_sum[SS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_level <= '0;
      ovl_clr   <= 1'b0;
      ss_clr    <= 1'b0;
    end else begin
      ovl_clr <= trip;
      ss_clr  <= trip;
      if (trip || !integ_on)
        ovl_level <= '0;
      else if (cyc_strobe)
        ovl_level <= ilim_evt ? up_sat : down_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiccup_active <= 1'b0;
      ss_level      <= '0;
      div_cnt       <= '0;
    end else if (trip) begin
      hiccup_active <= 1'b1;
      ss_level      <= '0;
      div_cnt       <= '0;
    end else begin
      if (release_now) hiccup_active <= 1'b0;
      div_cnt <= (hiccup_active && !slow_tick) ? div_cnt + DIV_W'(1) : '0;
      if (ss_adv) ss_level <= ss_next;
    end
  end

endmodule

// File: rtl/hiccup_restart_timer_chk.sv
module hiccup_restart_timer_chk #(
  parameter int ACC_W = 16,
  parameter int SS_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_strobe,
  input logic             ilim_evt,
  input logic             first_pulse,
  input logic [1:0]       prot_mode,
  input logic [SS_W-1:0]  pulse_level,
  input logic             hiccup_active,
  input logic [SS_W-1:0]  ss_level,
  input logic [ACC_W-1:0] ovl_level,
  input logic             ovl_clr,
  input logic             ss_clr
);

  // R1
  ovl_rise_needs_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_level > $past(ovl_level)) |-> $past(cyc_strobe && ilim_evt));

  // R2
  clear_empties_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_clr |-> (ovl_level == '0 && ss_level == '0 && hiccup_active));

  // R2
  hiccup_entry_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hiccup_active) |-> (ss_clr && ss_level == '0));

  // R4
  release_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hiccup_active) |-> $past(first_pulse && ss_level >= pulse_level));

  // R6
  limit_mode_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_clr |-> ($past(prot_mode) != 2'd0));

endmodule

bind hiccup_restart_timer hiccup_restart_timer_chk #(.ACC_W(ACC_W), .SS_W(SS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .ilim_evt(ilim_evt),
  .first_pulse(first_pulse), .prot_mode(prot_mode), .pulse_level(pulse_level),
  .hiccup_active(hiccup_active), .ss_level(ss_level), .ovl_level(ovl_level),
  .ovl_clr(ovl_clr), .ss_clr(ss_clr)
);

// File: tb/hiccup_restart_timer_test.sv
`timescale 1ns/1ps
module hiccup_restart_timer_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_strobe = 0, ilim_evt = 0, first_pulse = 0, ext_trig = 0;
  logic [1:0]  prot_mode = 2'd2;
  logic [15:0] trip_level = 16'd100, up_step = 16'd22, down_step = 16'd12;
  logic [15:0] ss_step = 16'd4, ss_full = 16'd200, pulse_level = 16'd4;
  logic hiccup_active, ovl_clr, ss_clr;
  logic [15:0] ss_level, ovl_level;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  hiccup_restart_timer uut (
    .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .ilim_evt(ilim_evt),
    .first_pulse(first_pulse), .ext_trig(ext_trig), .prot_mode(prot_mode),
    .trip_level(trip_level), .up_step(up_step), .down_step(down_step),
    .ss_step(ss_step), .ss_full(ss_full), .pulse_level(pulse_level),
    .hiccup_active(hiccup_active), .ss_level(ss_level), .ovl_level(ovl_level),
    .ovl_clr(ovl_clr), .ss_clr(ss_clr)
  );

  // strobe, ilim, expected ovl_level, expected hiccup_active
  localparam logic [18:0] VEC [0:11] = '{
    {1'b1, 1'b1, 16'd22,  1'b0},
    {1'b0, 1'b1, 16'd22,  1'b0},
    {1'b1, 1'b0, 16'd10,  1'b0},
    {1'b1, 1'b0, 16'd0,   1'b0},
    {1'b1, 1'b0, 16'd0,   1'b0},
    {1'b1, 1'b1, 16'd22,  1'b0},
    {1'b1, 1'b1, 16'd44,  1'b0},
    {1'b1, 1'b1, 16'd66,  1'b0},
    {1'b1, 1'b0, 16'd54,  1'b0},
    {1'b1, 1'b1, 16'd76,  1'b0},
    {1'b1, 1'b1, 16'd98,  1'b0},
    {1'b1, 1'b1, 16'd0,   1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    // R11 reset state
    chk("R11 hiccup", hiccup_active, 0);
    chk("R11 ss", ss_level, 0);
    chk("R11 ovl", ovl_level, 0);
    chk("R11 clr", {ovl_clr, ss_clr}, 0);
    rst_n = 1'b1;

    // R1 integration and R2 trip, delayed mode
    for (int v = 0; v < 12; v++) begin
      cyc_strobe = VEC[v][18];
      ilim_evt   = VEC[v][17];
      tick(1);
      chk("R1 ovl_level", ovl_level, VEC[v][16:1]);
      chk("R2 hiccup", hiccup_active, VEC[v][0]);
    end
    cyc_strobe = 0; ilim_evt = 0;
    chk("R2 ss cleared", ss_level, 0);
    chk("R2 clr pulses", {ovl_clr, ss_clr}, 2'b11);
    tick(1);
    chk("R2 clr one clock", {ovl_clr, ss_clr}, 2'b00);

    // R4 first pulse below level ignored
    first_pulse = 1;
    tick(1);
    first_pulse = 0;
    chk("R4 early pulse ignored", hiccup_active, 1);

    // R3 slow climb
    tick(107);
    chk("R3 still zero at 109", ss_level, 0);
    tick(1);
    chk("R3 advance at 110", ss_level, 4);

    // R4 release
    first_pulse = 1;
    tick(1);
    first_pulse = 0;
    chk("R4 release", hiccup_active, 0);

    // R5 normal rate and ceiling
    tick(1);
    chk("R5 normal step", ss_level, 8);
    tick(1);
    chk("R5 normal step", ss_level, 12);
    ss_full = 16'd10;
    tick(1);
    chk("R5 ceiling", ss_level, 10);
    ss_full = 16'd200;

    // R9 external trigger without strobe, R10 priority
    ext_trig = 1;
    tick(1);
    ext_trig = 0;
    chk("R9 ext trip", hiccup_active, 1);
    chk("R9 ext clear", ss_clr, 1);
    tick(110);
    chk("R3 second climb", ss_level, 4);
    ext_trig = 1; first_pulse = 1;
    tick(1);
    ext_trig = 0; first_pulse = 0;
    chk("R10 restart wins", hiccup_active, 1);
    chk("R10 ss cleared", ss_level, 0);
    chk("R10 clear pulse", ss_clr, 1);
    tick(110);
    first_pulse = 1;
    tick(1);
    first_pulse = 0;
    chk("R10 later release", hiccup_active, 0);

    // R6 limit-only mode
    prot_mode = 2'd0;
    cyc_strobe = 1; ilim_evt = 1;
    tick(3);
    chk("R6 no trip", hiccup_active, 0);
    chk("R6 ovl held", ovl_level, 0);
    cyc_strobe = 0; ilim_evt = 0; ext_trig = 1;
    tick(1);
    ext_trig = 0;
    chk("R6 ext ignored", {hiccup_active, ovl_clr}, 0);

    // R7 immediate mode
    prot_mode = 2'd1;
    ilim_evt = 1;
    tick(1);
    chk("R7 no strobe no trip", hiccup_active, 0);
    cyc_strobe = 1; ilim_evt = 0;
    tick(1);
    chk("R7 clean strobe", hiccup_active, 0);
    ilim_evt = 1;
    tick(1);
    cyc_strobe = 0; ilim_evt = 0;
    chk("R7 first limit trips", hiccup_active, 1);
    chk("R7 ovl held", ovl_level, 0);
    pulse_level = 16'd0;
    first_pulse = 1;
    tick(1);
    first_pulse = 0;
    chk("R4 release at zero level", hiccup_active, 0);
    pulse_level = 16'd4;

    // R8 external-only mode
    prot_mode = 2'd3;
    cyc_strobe = 1; ilim_evt = 1;
    tick(4);
    cyc_strobe = 0; ilim_evt = 0;
    chk("R8 limit ignored", hiccup_active, 0);
    chk("R8 ovl held", ovl_level, 0);
    ext_trig = 1;
    tick(1);
    ext_trig = 0;
    chk("R8 ext trips", hiccup_active, 1);

    finish_run();
  end

endmodule